// File: doc/BRIEF.md
# External Interrupt Line Controller

This block collects a bank of external interrupt lines, sixty-four by default, grouped into 32-bit words. Each line carries four attributes held in registers: a block bit, a trigger-mode bit (edge or level), a polarity bit and a software-pending bit. Every attribute except the enable word can be written in three ways. A plain write replaces the whole word. A set-alias write turns on the bits written as 1. A clear-alias write turns off the bits written as 1. Any read of the attribute, through any of its three addresses, returns the stored word.

Raw lines pass through a two-flop synchroniser. Edges are then found by comparing each synchronised sample with the one before it. In edge mode, the edge that the polarity selects is latched into a pending bit, and software clears it by writing 1 to the acknowledge word. In level mode, the pending view follows the active level directly. The pending word a processor reads is the OR of the latched edges, the active levels and the software bits. One registered interrupt output is high while any pending line is both unblocked and in an enabled domain.

The register interface is a plain single-cycle bus with word addresses. A write takes effect at the clock edge where it is presented. A read returns its data on the next edge, and that data then holds until the next read. The bus carries no stream, so it has no valid/ready handshake and never applies back-pressure.

Top module: `eic_top`

## Requirements
- R1: After reset the block word of every line is 1, the trigger-mode, polarity, software-pending and enable words are 0, every pending read returns 0 and irq_out is 0.
- R2: The word address is split as group = bus_addr[9:6] and word = bus_addr[5:2]. Line n is bit n%32 of word n/32. Group codes: 0 pending (read-only), 1 acknowledge, 2 enable, 3/4/5 block plain/set/clear, 6/7/8 polarity plain/set/clear, 9/10/11 trigger-mode plain/set/clear, 12/13/14 software-pending plain/set/clear. Writes to a word index at or beyond the word count, or to group 0, change nothing, and reads of such words return 0.
- R3: A set-alias write turns on exactly the bits written as 1, and a clear-alias write turns off exactly those bits. A plain write replaces the word. All three addresses of an attribute read back the stored word.
- R4: When a line's trigger-mode bit is 0 (edge), polarity 1 latches a rising edge and polarity 0 latches a falling edge into its pending bit. The opposite edge has no effect.
- R5: When a line's trigger-mode bit is 1 (level), its pending bit follows the input level: high is active with polarity 1, low is active with polarity 0. Nothing is latched.
- R6: Writing 1 to an acknowledge bit clears that line's latched edge, and 0 bits leave it alone. Acknowledge does not affect active levels or software-pending bits. The acknowledge group reads 0. An edge arriving in the same cycle as its acknowledge survives.
- R7: Setting a software-pending bit makes the line pending, and clearing it removes that source.
- R8: A block bit of 1 keeps the line out of irq_out, but the line is still shown in the pending read.
- R9: A line contributes to irq_out only while its enable bit is 1.
- R10: irq_out is a register. It goes high one cycle after any line is pending, unblocked and enabled, and is low otherwise.
- R11: bus_rdata is loaded on the clock edge where bus_rd is high and holds its value while bus_rd is low.
- R12: Each input passes two flops before edge detection. A change is not visible in a read captured on the second clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Word address, bits 9:2 of the byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| ext_line | input | NUM_LINES | Raw external interrupt lines |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bound checker watches several rules on every cycle. It confirms that set-alias and clear-alias writes to the block and software-pending words land exactly on the written bits. It confirms that irq_out stays low whenever the previous cycle had no enabled domain or every line blocked. It also confirms that read data holds between reads and that the acknowledge group reads 0. The bench scenarios cover the behaviours that depend on input history: edge selection by polarity, level following, the acknowledge leaving levels and software bits untouched, the synchroniser delay, and the address decode of out-of-range words.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int WORD_W   = 32;
  localparam int GRP_W    = 4;
  localparam int WIDX_W   = 4;
  localparam int ADDR_MSB = GRP_W + WIDX_W + 1;

  typedef enum logic [GRP_W-1:0] {
    G_PEND     = 4'd0,
    G_ACK      = 4'd1,
    G_EN       = 4'd2,
    G_MASK     = 4'd3,
    G_MASK_SET = 4'd4,
    G_MASK_CLR = 4'd5,
    G_POL      = 4'd6,
    G_POL_SET  = 4'd7,
    G_POL_CLR  = 4'd8,
    G_MODE     = 4'd9,
    G_MODE_SET = 4'd10,
    G_MODE_CLR = 4'd11,
    G_SOFT     = 4'd12,
    G_SOFT_SET = 4'd13,
    G_SOFT_CLR = 4'd14,
    G_NONE     = 4'd15
  } eic_grp_e;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] smp_q,
  output logic [W-1:0] prv_q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      smp_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= din;
      smp_q  <= meta_q;
      prv_q  <= smp_q;
    end
  end
endmodule

// File: rtl/eic_attr.sv
module eic_attr import eic_pkg::*; #(
  parameter int   NUM_WORDS = 2,
  parameter logic RST_VAL   = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_plain,
  input  logic                        wr_set,
  input  logic                        wr_clr,
  input  logic [WIDX_W-1:0]           widx,
  input  logic [WORD_W-1:0]           wdata,
  output logic [NUM_WORDS*WORD_W-1:0] q
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              hit;
    assign hit = (widx == WIDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= {WORD_W{RST_VAL}};
      end else if (hit) begin
        if (wr_plain)    word_q <= wdata;
        else if (wr_set) word_q <= word_q | wdata;
        else if (wr_clr) word_q <= word_q & ~wdata;
      end
    end
    assign q[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/eic_detect.sv
module eic_detect #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] prv,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] ack,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] lvl_act
);
  logic [W-1:0] rise, fall, edge_ev;

  assign rise    = smp & ~prv;
  assign fall    = ~smp & prv;
  assign edge_ev = ~mode & ((pol & rise) | (~pol & fall));
  assign lvl_act = mode & ~(smp ^ pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= (latch_q & ~ack) | edge_ev;
  end
endmodule

// File: rtl/eic_top.sv
module eic_top import eic_pkg::*; #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_MSB:2]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] ext_line,
  output logic                 irq_out
);
  localparam int NUM_WORDS = NUM_LINES / WORD_W;
  localparam logic [WIDX_W:0] NW = (WIDX_W+1)'(NUM_WORDS);

  eic_grp_e          grp;
  logic [WIDX_W-1:0] widx;
  logic              widx_ok;

  assign grp     = eic_grp_e'(bus_addr[ADDR_MSB -: GRP_W]);
  assign widx    = bus_addr[ADDR_MSB-GRP_W -: WIDX_W];
  assign widx_ok = ({1'b0, widx} < NW);

  function automatic logic [WORD_W-1:0] word_of(input logic [NUM_LINES-1:0] v,
                                                input logic [WIDX_W-1:0] i);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (i == WIDX_W'(w)) r = v[w*WORD_W +: WORD_W];
    return r;
  endfunction

  function automatic logic wr_hit(input logic wr, input eic_grp_e g, input eic_grp_e want);
    return wr && (g == want);
  endfunction

  logic [NUM_LINES-1:0] mask_q, pol_q, mode_q, soft_q, en_q;

  eic_attr #(.NUM_WORDS(NUM_WORDS), .RST_VAL(1'b1)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .wr_plain(wr_hit(bus_wr, grp, G_MASK)),
    .wr_set(wr_hit(bus_wr, grp, G_MASK_SET)),
    .wr_clr(wr_hit(bus_wr, grp, G_MASK_CLR)),
    .widx(widx), .wdata(bus_wdata), .q(mask_q)
  );

  eic_attr #(.NUM_WORDS(NUM_WORDS), .RST_VAL(1'b0)) u_pol (
    .clk(clk), .rst_n(rst_n),
    .wr_plain(wr_hit(bus_wr, grp, G_POL)),
    .wr_set(wr_hit(bus_wr, grp, G_POL_SET)),
    .wr_clr(wr_hit(bus_wr, grp, G_POL_CLR)),
    .widx(widx), .wdata(bus_wdata), .q(pol_q)
  );

  eic_attr #(.NUM_WORDS(NUM_WORDS), .RST_VAL(1'b0)) u_mode (
    .clk(clk), .rst_n(rst_n),
    .wr_plain(wr_hit(bus_wr, grp, G_MODE)),
    .wr_set(wr_hit(bus_wr, grp, G_MODE_SET)),
    .wr_clr(wr_hit(bus_wr, grp, G_MODE_CLR)),
    .widx(widx), .wdata(bus_wdata), .q(mode_q)
  );

  eic_attr #(.NUM_WORDS(NUM_WORDS), .RST_VAL(1'b0)) u_soft (
    .clk(clk), .rst_n(rst_n),
    .wr_plain(wr_hit(bus_wr, grp, G_SOFT)),
    .wr_set(wr_hit(bus_wr, grp, G_SOFT_SET)),
    .wr_clr(wr_hit(bus_wr, grp, G_SOFT_CLR)),
    .widx(widx), .wdata(bus_wdata), .q(soft_q)
  );

  eic_attr #(.NUM_WORDS(NUM_WORDS), .RST_VAL(1'b0)) u_en (
    .clk(clk), .rst_n(rst_n),
    .wr_plain(wr_hit(bus_wr, grp, G_EN)),
    .wr_set(1'b0),
    .wr_clr(1'b0),
    .widx(widx), .wdata(bus_wdata), .q(en_q)
  );

  // Acknowledge vector: the written word lands on the addressed word only.
  logic [NUM_LINES-1:0] ack_vec;
  always_comb begin
    ack_vec = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (wr_hit(bus_wr, grp, G_ACK) && widx == WIDX_W'(w))
        ack_vec[w*WORD_W +: WORD_W] = bus_wdata;
  end

  logic [NUM_LINES-1:0] smp, prv;
  eic_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_line), .smp_q(smp), .prv_q(prv)
  );

  logic [NUM_LINES-1:0] latch_q, lvl_act, status;
  eic_detect #(.W(NUM_LINES)) u_det (
    .clk(clk), .rst_n(rst_n), .smp(smp), .prv(prv),
    .mode(mode_q), .pol(pol_q), .ack(ack_vec),
    .latch_q(latch_q), .lvl_act(lvl_act)
  );

  assign status = latch_q | lvl_act | soft_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |(status & ~mask_q & en_q);
  end

  logic [WORD_W-1:0] rd_word;
  always_comb begin
    unique case (grp)
      G_PEND:                          rd_word = word_of(status, widx);
      G_EN:                            rd_word = word_of(en_q, widx);
      G_MASK, G_MASK_SET, G_MASK_CLR:  rd_word = word_of(mask_q, widx);
      G_POL, G_POL_SET, G_POL_CLR:     rd_word = word_of(pol_q, widx);
      G_MODE, G_MODE_SET, G_MODE_CLR:  rd_word = word_of(mode_q, widx);
      G_SOFT, G_SOFT_SET, G_SOFT_CLR:  rd_word = word_of(soft_q, widx);
      default:                         rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= widx_ok ? rd_word : '0;
  end
endmodule

// File: rtl/eic_checker.sv
module eic_checker import eic_pkg::*; #(
  parameter int NUM_LINES = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [ADDR_MSB:2]    bus_addr,
  input logic [WORD_W-1:0]    bus_wdata,
  input logic [WORD_W-1:0]    bus_rdata,
  input logic                 irq_out,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] soft_q,
  input logic [NUM_LINES-1:0] en_q
);
  localparam int NUM_WORDS = NUM_LINES / WORD_W;

  function automatic logic [WORD_W-1:0] pick(input logic [NUM_LINES-1:0] v,
                                             input logic [WIDX_W-1:0] i);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (i == WIDX_W'(w)) r = v[w*WORD_W +: WORD_W];
    return r;
  endfunction

  logic [GRP_W-1:0]  c_grp;
  logic [WIDX_W-1:0] c_widx;
  logic              c_ok;
  assign c_grp  = bus_addr[ADDR_MSB -: GRP_W];
  assign c_widx = bus_addr[ADDR_MSB-GRP_W -: WIDX_W];
  assign c_ok   = (int'(c_widx) < NUM_WORDS);

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && c_ok && c_grp == G_MASK_SET) |=>
      ((pick(mask_q, $past(c_widx)) & $past(bus_wdata)) == $past(bus_wdata)));

  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && c_ok && c_grp == G_MASK_CLR) |=>
      ((pick(mask_q, $past(c_widx)) & $past(bus_wdata)) == '0));

  assert_soft_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && c_ok && c_grp == G_SOFT_SET) |=>
      ((pick(soft_q, $past(c_widx)) & $past(bus_wdata)) == $past(bus_wdata)));

  assert_soft_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && c_ok && c_grp == G_SOFT_CLR) |=>
      ((pick(soft_q, $past(c_widx)) & $past(bus_wdata)) == '0));

  assert_all_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(mask_q)) |-> !irq_out);

  assert_no_domain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|$past(en_q)) |-> !irq_out);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_ack_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && c_grp == G_ACK) |=> (bus_rdata == '0));
endmodule

bind eic_top eic_checker #(.NUM_LINES(NUM_LINES)) u_eic_checker (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .mask_q(mask_q), .soft_q(soft_q), .en_q(en_q)
);

// File: tb/test_eic_top.sv
module test_eic_top;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [9:2]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] ext_line = '1;
  logic        irq_out;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  eic_top #(.NUM_LINES(N)) i_eic_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_line(ext_line), .irq_out(irq_out)
  );

  function automatic logic [9:2] ad(input int grp, input int word);
    return {4'(grp), 4'(word)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int grp, input int word, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ad(grp, word); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int grp, input int word, output logic [31:0] d);
    bus_addr = ad(grp, word); bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int w = 0; w < 2; w++) begin
      rd(3, w, d);  chk("R1 block word", d, 32'hFFFF_FFFF);
      rd(6, w, d);  chk("R1 polarity word", d, 32'h0);
      rd(9, w, d);  chk("R1 mode word", d, 32'h0);
      rd(12, w, d); chk("R1 soft word", d, 32'h0);
      rd(2, w, d);  chk("R1 enable word", d, 32'h0);
      rd(0, w, d);  chk("R1 pending word", d, 32'h0);
    end
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_alias();
    logic [31:0] d;
    wr(3, 1, 32'h0000_00F0);
    wr(4, 1, 32'h0000_0003);
    wr(5, 1, 32'h0000_0010);
    @(negedge clk);
    rd(3, 1, d); chk("R3 block plain/set/clear", d, 32'h0000_00E3);
    rd(4, 1, d); chk("R3 read via set alias", d, 32'h0000_00E3);
    rd(5, 1, d); chk("R3 read via clear alias", d, 32'h0000_00E3);
    wr(3, 1, 32'hFFFF_FFFF);
    wr(7, 0, 32'h0000_0100);
    wr(8, 0, 32'h0000_0000);
    @(negedge clk);
    rd(6, 0, d); chk("R3 zero bits of clear alias", d, 32'h0000_0100);
    wr(6, 0, 32'h0);
  endtask

  task automatic t_edge_rise();
    logic [31:0] d;
    wr(5, 0, 32'h8);
    wr(7, 0, 32'h8);
    ext_line[3] = 1'b0;
    idle(6);
    rd(0, 0, d); chk("R4 falling ignored when rising selected", d, 32'h0);
    ext_line[3] = 1'b1;
    idle(1);
    rd(0, 0, d); chk("R12 not visible after two edges", d, 32'h0);
    idle(4);
    rd(0, 0, d); chk("R4 rising edge latched", d, 32'h8);
    chk("R10 irq on pending line", {31'b0, irq_out}, 32'h1);
    ext_line[3] = 1'b0;
    idle(6);
    rd(0, 0, d); chk("R4 latch holds after input returns", d, 32'h8);
    wr(1, 0, 32'h8);
    idle(2);
    rd(0, 0, d); chk("R6 acknowledge clears edge", d, 32'h0);
    chk("R10 irq drops", {31'b0, irq_out}, 32'h0);
    wr(4, 0, 32'h8);
    ext_line[3] = 1'b1;
    idle(6);
    wr(1, 0, 32'h8);
    wr(8, 0, 32'h8);
  endtask

  task automatic t_edge_fall();
    logic [31:0] d;
    wr(5, 1, 32'h100);
    ext_line[40] = 1'b0;
    idle(6);
    rd(0, 1, d); chk("R2 R4 line 40 falling edge in word 1 bit 8", d, 32'h100);
    wr(1, 1, 32'h1);
    idle(1);
    rd(0, 1, d); chk("R6 zero acknowledge bits no effect", d, 32'h100);
    wr(1, 1, 32'h100);
    idle(1);
    rd(0, 1, d); chk("R6 acknowledge line 40", d, 32'h0);
    ext_line[40] = 1'b1;
    idle(6);
    rd(0, 1, d); chk("R4 rising ignored with polarity 0", d, 32'h0);
    chk("R10 irq low", {31'b0, irq_out}, 32'h0);
    wr(4, 1, 32'h100);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(10, 0, 32'h20);
    wr(7, 0, 32'h20);
    wr(5, 0, 32'h20);
    idle(3);
    rd(0, 0, d); chk("R5 active high level", d, 32'h20);
    chk("R5 irq from level", {31'b0, irq_out}, 32'h1);
    wr(1, 0, 32'h20);
    idle(1);
    rd(0, 0, d); chk("R6 acknowledge leaves level", d, 32'h20);
    ext_line[5] = 1'b0;
    idle(5);
    rd(0, 0, d); chk("R5 level released", d, 32'h0);
    chk("R5 irq drops with level", {31'b0, irq_out}, 32'h0);
    wr(8, 0, 32'h20);
    idle(2);
    rd(0, 0, d); chk("R5 active low level", d, 32'h20);
    wr(4, 0, 32'h20);
    wr(11, 0, 32'h20);
    ext_line[5] = 1'b1;
    idle(6);
    rd(0, 0, d); chk("R4 rising ignored after return to edge mode", d, 32'h0);
  endtask

  task automatic t_soft();
    logic [31:0] d;
    wr(5, 0, 32'h80);
    wr(13, 0, 32'h80);
    idle(2);
    rd(0, 0, d);  chk("R7 software pending visible", d, 32'h80);
    rd(12, 0, d); chk("R7 soft word", d, 32'h80);
    chk("R7 irq from software bit", {31'b0, irq_out}, 32'h1);
    wr(1, 0, 32'h80);
    idle(1);
    rd(0, 0, d); chk("R6 acknowledge leaves software bit", d, 32'h80);
    wr(14, 0, 32'h80);
    idle(2);
    rd(0, 0, d); chk("R7 software clear", d, 32'h0);
    chk("R7 irq drops", {31'b0, irq_out}, 32'h0);
    wr(4, 0, 32'h80);
  endtask

  task automatic t_mask_domain();
    logic [31:0] d;
    wr(13, 1, 32'h200);
    idle(2);
    rd(0, 1, d); chk("R8 blocked line still pending", d, 32'h200);
    chk("R8 blocked line no irq", {31'b0, irq_out}, 32'h0);
    wr(5, 1, 32'h200);
    idle(2);
    chk("R8 unblocked line raises irq", {31'b0, irq_out}, 32'h1);
    wr(2, 1, 32'h0);
    idle(2);
    chk("R9 disabled domain no irq", {31'b0, irq_out}, 32'h0);
    wr(2, 1, 32'hFFFF_FFFF);
    idle(2);
    chk("R9 enabled domain irq", {31'b0, irq_out}, 32'h1);
    wr(14, 1, 32'h200);
    wr(4, 1, 32'h200);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    wr(3, 5, 32'h0);
    wr(13, 5, 32'hFFFF_FFFF);
    wr(0, 0, 32'hFFFF_FFFF);
    idle(1);
    rd(3, 5, d);  chk("R2 out-of-range word reads 0", d, 32'h0);
    rd(3, 0, d);  chk("R2 out-of-range write ignored w0", d, 32'hFFFF_FFFF);
    rd(3, 1, d);  chk("R2 out-of-range write ignored w1", d, 32'hFFFF_FFFF);
    rd(12, 0, d); chk("R2 soft w0 untouched", d, 32'h0);
    rd(0, 0, d);  chk("R2 pending group not writable", d, 32'h0);
    rd(1, 0, d);  chk("R6 acknowledge group reads 0", d, 32'h0);
  endtask

  task automatic t_read_hold();
    logic [31:0] d;
    rd(3, 0, d);
    wr(13, 0, 32'h1);
    idle(3);
    chk("R11 rdata holds without read", bus_rdata, 32'hFFFF_FFFF);
    rd(0, 0, d); chk("R11 new read loads", d, 32'h1);
    wr(14, 0, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    wr(2, 0, 32'hFFFF_FFFF);
    wr(2, 1, 32'hFFFF_FFFF);
    t_alias();
    t_edge_rise();
    t_edge_fall();
    t_level();
    t_soft();
    t_mask_domain();
    t_decode();
    t_read_hold();
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule